// File: doc/BRIEF.md
# Remote Function-Call Bus Bridge

This block carries one function call at a time from a local requester to a remote function unit across a memory-mapped bus with a single-cycle valid/ready handshake. It holds two cooperating adapters joined by that bus. The caller-side adapter accepts a function number, a parameter count and up to eight parameter words. It stores them and writes the parameters one word per bus write into the callee-side adapter's parameter registers. A single write to a control register then launches the call.

The callee-side adapter keeps every parameter register until it is overwritten. On the control write it sends a one-cycle start strobe to the function unit, together with the function number and all parameter registers. It captures the result when the unit reports completion, and then raises a done bit in its status register. The caller-side adapter reads the status register once per cycle until done is set. It then reads the result register, which clears done, and hands the result to its requester with a one-cycle pulse.

Top module: `rpc_bridge`

## Requirements
- R1: After reset `call_ready` is 1, `res_valid` is 0 and `fu_start` is 0. `call_ready` is 1 exactly when no call is in flight, and it returns to 1 in the cycle that `res_valid` pulses.
- R2: For an accepted call the caller side issues min(`call_nparam`, 8) parameter writes, one word per bus write, to parameter offsets 0, 1, 2 … in ascending order, and then exactly one control write. A count above 8 is treated as 8, and a count of 0 sends only the control write.
- R3: Each parameter register keeps its value until a call writes it. A call with fewer parameters leaves the higher registers as earlier calls left them. Register i appears on `fu_params[32*i+31:32*i]`, and all registers are 0 after reset.
- R4: `fu_start` is a one-cycle pulse in the cycle n+2 after the accepting cycle (n being the clamped parameter count). It is raised only after a control write. `fu_fid` then equals the accepted `call_fid`.
- R5: A `fu_done` pulse while no call is busy on the callee side is ignored. It produces no `res_valid` and does not change the result delivered by any later call.
- R6: The caller side reads the status register on every cycle until its done bit reads 1. `res_valid` is a one-cycle pulse three cycles after the cycle in which `fu_done` was high, and `res_data` carries the captured result.
- R7: Reading the result register clears the done bit. A following call therefore completes only through its own `fu_done`, with the same latency as R6.
- R8: The bus uses byte addresses `BASE + 4*offset`. Offsets 0–7 are the parameter registers. Offset 8 is the control register, with the function number in bits 7:0. Offset 9 is the status register, with done in bit 0 and busy in bit 1. Offset 10 is the result register. The callee side accepts every bus request in the cycle it is presented, and the first bus read after the control write is a status read.
- R9: The result is taken from `fu_result` in the first cycle that `fu_done` is high while the call is busy. Values on `fu_result` in any other cycle do not reach `res_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_valid | input | 1 | Requester presents a call |
| call_ready | output | 1 | Bridge idle; a call is accepted when valid and ready |
| call_fid | input | 8 | Function number of the call |
| call_nparam | input | 4 | Number of parameter words (above 8 treated as 8) |
| call_params | input | 256 | Parameter words, word i in bits 32i+31:32i |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_data | output | 32 | Result of the completed call |
| fu_start | output | 1 | One-cycle start strobe to the function unit |
| fu_fid | output | 8 | Function number for the function unit |
| fu_params | output | 256 | All parameter registers held on the callee side |
| fu_done | input | 1 | Function unit completion strobe |
| fu_result | input | 32 | Function unit result, valid with fu_done |

## Verification
Suppose the caller-side state or word counter goes wrong. Then the start strobe moves away from its cycle n+2, or the parameter registers shown at start differ from the expected image, and this shows up in the first call. Suppose the callee side fails to clear done, or captures the result in the wrong cycle. Then the next call's result pulse comes early, or its result word is wrong, one call later at the most. The bench predicts `call_ready`, `fu_start` and `res_valid` on every clock, so an error surfaces within a cycle of the moment it reaches a port.

// File: rtl/rpcb_pkg.sv
// Shared constants and types for the remote function-call bridge.
// Assumes a word-addressed register map, word i at byte address BASE + 4*i.
package rpcb_pkg;
    // register offsets on the callee side (word units)
    localparam int unsigned OFS_CTRL = 8;
    localparam int unsigned OFS_STAT = 9;
    localparam int unsigned OFS_RES  = 10;
    localparam int unsigned OFS_W    = 4;   // offset field width in the address

    // status register bit positions
    localparam int unsigned ST_DONE = 0;
    localparam int unsigned ST_BUSY = 1;

    // caller-side sequencer states
    typedef enum logic [2:0] {
        M_IDLE,
        M_PARAM,
        M_CTRL,
        M_POLL,
        M_RESULT
    } mst_state_e;
endpackage

// File: rtl/rpcb_param_bank.sv
// Parameter register bank of the callee-side adapter.
// Holds NREG words, each written alone by index; all words are presented
// in parallel and one word is readable by index. Assumes NREG >= 2.
module rpcb_param_bank #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [NREG*DW-1:0] all_q
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        // one storage word, written only when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign all_q[g*DW +: DW] = regs[g];
    end

    // indexed read port
    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/rpcb_master.sv
// Caller-side adapter. Accepts a call from the local requester, stores it,
// writes parameters word by word to the callee registers, writes the control
// register, polls status once per cycle until done, reads the result and
// pulses res_valid. Assumes a single bus initiator and a callee at BASE.
module rpcb_master
    import rpcb_pkg::*;
#(
    parameter int          NREG = 8,
    parameter int          DW   = 32,
    parameter int          AW   = 32,
    parameter int          FIDW = 8,
    parameter int          NCW  = 4,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_valid,
    output logic                call_ready,
    input  logic [FIDW-1:0]     call_fid,
    input  logic [NCW-1:0]      call_nparam,
    input  logic [NREG*DW-1:0]  call_params,
    output logic                res_valid,
    output logic [DW-1:0]       res_data,
    output logic                bus_valid,
    output logic                bus_write,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       bus_wdata,
    input  logic                bus_ready,
    input  logic [DW-1:0]       bus_rdata
);
    localparam int CW = $clog2(NREG + 1);
    localparam logic [AW-1:0] A_CTRL = BASE + AW'(OFS_CTRL * 4);
    localparam logic [AW-1:0] A_STAT = BASE + AW'(OFS_STAT * 4);
    localparam logic [AW-1:0] A_RES  = BASE + AW'(OFS_RES * 4);

    mst_state_e          state_q;
    logic [CW-1:0]       idx_q;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       n_eff;
    logic [FIDW-1:0]     fid_q;
    logic [NREG*DW-1:0]  par_q;
    logic                res_valid_q;
    logic [DW-1:0]       res_data_q;
    logic                take;

    assign call_ready = (state_q == M_IDLE);
    assign take       = call_valid && call_ready;
    assign res_valid  = res_valid_q;
    assign res_data   = res_data_q;

    // clamp the requested parameter count to the register bank size
    always_comb begin
        if (call_nparam > NCW'(NREG)) n_eff = CW'(NREG);
        else                          n_eff = CW'(call_nparam);
    end

    // drive the bus request for the current step of the sequence
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = BASE;
        bus_wdata = '0;
        case (state_q)
            M_PARAM: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = BASE + (AW'(idx_q) << 2);
                bus_wdata = par_q[idx_q*DW +: DW];
            end
            M_CTRL: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = A_CTRL;
                bus_wdata = DW'(fid_q);
            end
            M_POLL: begin
                bus_valid = 1'b1;
                bus_addr  = A_STAT;
            end
            M_RESULT: begin
                bus_valid = 1'b1;
                bus_addr  = A_RES;
            end
            default: ;
        endcase
    end

    // sequencer: call acceptance, parameter stepping, polling, result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= M_IDLE;
            idx_q       <= '0;
            cnt_q       <= '0;
            res_valid_q <= 1'b0;
        end else begin
            res_valid_q <= 1'b0;
            case (state_q)
                M_IDLE: begin
                    if (take) begin
                        idx_q   <= '0;
                        cnt_q   <= n_eff;
                        state_q <= (n_eff == '0) ? M_CTRL : M_PARAM;
                    end
                end
                M_PARAM: begin
                    if (bus_ready) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == cnt_q - 1'b1) state_q <= M_CTRL;
                    end
                end
                M_CTRL: begin
                    if (bus_ready) state_q <= M_POLL;
                end
                M_POLL: begin
                    if (bus_ready && bus_rdata[ST_DONE]) state_q <= M_RESULT;
                end
                M_RESULT: begin
                    if (bus_ready) begin
                        res_valid_q <= 1'b1;
                        state_q     <= M_IDLE;
                    end
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    // call data and result capture (no reset needed on data)
    always_ff @(posedge clk) begin
        if (take) begin
            fid_q <= call_fid;
            par_q <= call_params;
        end
        if (state_q == M_RESULT && bus_ready) res_data_q <= bus_rdata;
    end
endmodule

// File: rtl/rpcb_slave.sv
// Callee-side adapter. Decodes the register map at BASE, stores parameter
// words, launches the function unit on a control write when not busy,
// captures the result on fu_done and reports done/busy in status.
// Reading the result register clears done. Accepts every request at once.
module rpcb_slave
    import rpcb_pkg::*;
#(
    parameter int          NREG = 8,
    parameter int          DW   = 32,
    parameter int          AW   = 32,
    parameter int          FIDW = 8,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic                bus_ready,
    output logic [DW-1:0]       bus_rdata,
    output logic                fu_start,
    output logic [FIDW-1:0]     fu_fid,
    output logic [NREG*DW-1:0]  fu_params,
    input  logic                fu_done,
    input  logic [DW-1:0]       fu_result
);
    localparam int IW = $clog2(NREG);
    localparam int LO = OFS_W + 2;

    logic [OFS_W-1:0] ofs;
    logic             hit, acc;
    logic             param_we, ctrl_we, res_rd;
    logic             busy_q, done_q, start_q;
    logic [FIDW-1:0]  fid_q;
    logic [DW-1:0]    result_q;
    logic [DW-1:0]    param_rd;

    // address decode
    assign ofs       = bus_addr[LO-1:2];
    assign hit       = (bus_addr[AW-1:LO] == BASE[AW-1:LO]) && (bus_addr[1:0] == 2'b00);
    assign bus_ready = 1'b1;
    assign acc       = bus_valid && bus_ready && hit;
    assign param_we  = acc && bus_write && (ofs < OFS_W'(NREG));
    assign ctrl_we   = acc && bus_write && (ofs == OFS_W'(OFS_CTRL));
    assign res_rd    = acc && !bus_write && (ofs == OFS_W'(OFS_RES));

    rpcb_param_bank #(
        .NREG (NREG),
        .DW   (DW),
        .IW   (IW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (param_we),
        .wr_idx  (ofs[IW-1:0]),
        .wr_data (bus_wdata),
        .rd_idx  (ofs[IW-1:0]),
        .rd_data (param_rd),
        .all_q   (fu_params)
    );

    // call control: launch, completion capture, done clear on result read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            start_q  <= 1'b0;
            fid_q    <= '0;
            result_q <= '0;
        end else begin
            start_q <= 1'b0;
            if (ctrl_we && !busy_q) begin
                fid_q   <= bus_wdata[FIDW-1:0];
                busy_q  <= 1'b1;
                done_q  <= 1'b0;
                start_q <= 1'b1;
            end else if (busy_q && fu_done) begin
                result_q <= fu_result;
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
            end
            if (res_rd) done_q <= 1'b0;
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (ofs < OFS_W'(NREG)) begin
            bus_rdata = param_rd;
        end else if (ofs == OFS_W'(OFS_CTRL)) begin
            bus_rdata = DW'(fid_q);
        end else if (ofs == OFS_W'(OFS_STAT)) begin
            bus_rdata[ST_DONE] = done_q;
            bus_rdata[ST_BUSY] = busy_q;
        end else if (ofs == OFS_W'(OFS_RES)) begin
            bus_rdata = result_q;
        end
    end

    assign fu_start = start_q;
    assign fu_fid   = fid_q;
endmodule

// File: rtl/rpc_bridge.sv
// Top of the remote function-call bridge: caller-side adapter and callee-side
// adapter joined by a single-initiator bus with a one-cycle valid/ready
// handshake. Assumes BASE is aligned to 64 bytes and NREG <= 8.
module rpc_bridge #(
    parameter int          NREG = 8,
    parameter int          DW   = 32,
    parameter int          AW   = 32,
    parameter int          FIDW = 8,
    parameter int          NCW  = 4,
    parameter logic [AW-1:0] BASE = 32'h0000_4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_valid,
    output logic                call_ready,
    input  logic [FIDW-1:0]     call_fid,
    input  logic [NCW-1:0]      call_nparam,
    input  logic [NREG*DW-1:0]  call_params,
    output logic                res_valid,
    output logic [DW-1:0]       res_data,
    output logic                fu_start,
    output logic [FIDW-1:0]     fu_fid,
    output logic [NREG*DW-1:0]  fu_params,
    input  logic                fu_done,
    input  logic [DW-1:0]       fu_result
);
    logic          bus_valid;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready;
    logic [DW-1:0] bus_rdata;

    rpcb_master #(
        .NREG (NREG), .DW (DW), .AW (AW), .FIDW (FIDW), .NCW (NCW), .BASE (BASE)
    ) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_valid  (call_valid),
        .call_ready  (call_ready),
        .call_fid    (call_fid),
        .call_nparam (call_nparam),
        .call_params (call_params),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata)
    );

    rpcb_slave #(
        .NREG (NREG), .DW (DW), .AW (AW), .FIDW (FIDW), .BASE (BASE)
    ) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .fu_start  (fu_start),
        .fu_fid    (fu_fid),
        .fu_params (fu_params),
        .fu_done   (fu_done),
        .fu_result (fu_result)
    );
endmodule

// File: rtl/rpc_bridge_chk.sv
// Protocol checker for rpc_bridge, bound to the top. Watches the internal
// bus and the local strobes; assumes the register map of rpcb_pkg.
module rpc_bridge_chk
    import rpcb_pkg::*;
#(
    parameter int          AW   = 32,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_ready,
    input  logic          stat_done,
    input  logic          fu_start,
    input  logic          res_valid,
    input  logic          call_ready
);
    localparam logic [AW-1:0] A_CTRL = BASE + AW'(OFS_CTRL * 4);
    localparam logic [AW-1:0] A_STAT = BASE + AW'(OFS_STAT * 4);
    localparam logic [AW-1:0] A_RES  = BASE + AW'(OFS_RES * 4);

    logic ctrl_wr, stat_rd, res_rd;
    assign ctrl_wr = bus_valid && bus_ready && bus_write && (bus_addr == A_CTRL);
    assign stat_rd = bus_valid && bus_ready && !bus_write && (bus_addr == A_STAT);
    assign res_rd  = bus_valid && bus_ready && !bus_write && (bus_addr == A_RES);

    a_r4_start_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        fu_start |-> $past(ctrl_wr));
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fu_start |=> !fu_start);
    a_r6_poll_each_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_done) |=> stat_rd);
    a_r6_result_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd |-> $past(stat_rd && stat_done));
    a_r6_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r1_idle_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        call_ready |-> !bus_valid);
    a_r8_status_first_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> stat_rd);
endmodule

bind rpc_bridge rpc_bridge_chk #(.AW(AW), .BASE(BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .stat_done  (bus_rdata[0]),
    .fu_start   (fu_start),
    .res_valid  (res_valid),
    .call_ready (call_ready)
);

// File: tb/tb_rpc_bridge.sv
// Bench for rpc_bridge: behavioural reference with a parameter image,
// predicted strobe cycles and a modelled function unit; compares every clock.
module tb_rpc_bridge;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int FIDW = 8;
    localparam int NCW  = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                call_valid = 1'b0;
    logic                call_ready;
    logic [FIDW-1:0]     call_fid = '0;
    logic [NCW-1:0]      call_nparam = '0;
    logic [NREG*DW-1:0]  call_params = '0;
    logic                res_valid;
    logic [DW-1:0]       res_data;
    logic                fu_start;
    logic [FIDW-1:0]     fu_fid;
    logic [NREG*DW-1:0]  fu_params;
    logic                fu_done = 1'b0;
    logic [DW-1:0]       fu_result = '0;

    always #4 clk = ~clk;   // 125 MHz

    rpc_bridge dut (
        .clk (clk), .rst_n (rst_n),
        .call_valid (call_valid), .call_ready (call_ready),
        .call_fid (call_fid), .call_nparam (call_nparam), .call_params (call_params),
        .res_valid (res_valid), .res_data (res_data),
        .fu_start (fu_start), .fu_fid (fu_fid), .fu_params (fu_params),
        .fu_done (fu_done), .fu_result (fu_result)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit checking = 1'b0;

    // reference model state
    logic [NREG*DW-1:0] mdl_regs = '0;
    logic [FIDW-1:0]    exp_fid = '0;
    logic [DW-1:0]      exp_result = '0;
    bit                 inflight = 1'b0;
    int                 exp_start = -1;
    int                 exp_res = -1;
    int                 cur_lat = 0;
    int                 fu_cnt = -1;
    bit                 stray_req = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] fold(input logic [FIDW-1:0] f,
                                           input logic [NREG*DW-1:0] p);
        logic [DW-1:0] r;
        r = {f, 24'h00_0000};
        for (int i = 0; i < NREG; i++) r = {r[30:0], r[31]} ^ p[i*DW +: DW];
        return r;
    endfunction

    // per-cycle comparison and function unit model
    always @(negedge clk) begin
        if (checking) begin
            chk("R2/R4", "fu_start", {31'd0, fu_start}, {31'd0, inflight && (cyc == exp_start)});
            chk("R6/R7", "res_valid", {31'd0, res_valid}, {31'd0, inflight && (cyc == exp_res)});
            chk("R1", "call_ready", {31'd0, call_ready}, {31'd0, !inflight || (cyc == exp_res)});
            if (fu_start) begin
                chk("R4/R8", "fu_fid", {24'd0, fu_fid}, {24'd0, exp_fid});
                for (int i = 0; i < NREG; i++)
                    chk("R3", $sformatf("fu_params word %0d", i),
                        fu_params[i*DW +: DW], mdl_regs[i*DW +: DW]);
                exp_result = fold(exp_fid, mdl_regs);
                exp_res    = cyc + cur_lat + 3;
                fu_cnt     = cur_lat;
            end
            if (res_valid) begin
                chk("R6 R9", "res_data", res_data, exp_result);
                inflight  = 1'b0;
                exp_start = -1;
                exp_res   = -1;
            end
            if (call_valid && call_ready) begin
                int n;
                n = (call_nparam > NREG) ? NREG : int'(call_nparam);
                for (int i = 0; i < n; i++) mdl_regs[i*DW +: DW] = call_params[i*DW +: DW];
                exp_fid   = call_fid;
                inflight  = 1'b1;
                exp_start = cyc + n + 2;
            end
            // function unit drive
            fu_done   = 1'b0;
            fu_result = 32'hDEAD_0000 ^ cyc;
            if (fu_cnt == 0) begin
                fu_done   = 1'b1;
                fu_result = exp_result;
                fu_cnt    = -1;
            end else if (fu_cnt > 0) begin
                fu_cnt--;
            end else if (stray_req) begin
                fu_done   = 1'b1;
                fu_result = 32'hBAD0_BAD0;
                stray_req = 1'b0;
            end
        end
    end

    task automatic do_call(input logic [FIDW-1:0] f, input int n, input int lat, input int seed);
        @(posedge clk); #1;
        cur_lat     = lat;
        call_fid    = f;
        call_nparam = NCW'(n);
        for (int i = 0; i < NREG; i++) call_params[i*DW +: DW] = {seed[7:0], 8'h5A, 8'(i), 8'(seed * 3 + i)};
        call_valid  = 1'b1;
        do @(negedge clk); while (!call_ready);
        @(posedge clk); #1;
        call_valid  = 1'b0;
        do @(negedge clk); while (inflight);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        chk("R1", "reset call_ready", {31'd0, call_ready}, 32'd1);
        chk("R1", "reset res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1", "reset fu_start", {31'd0, fu_start}, 32'd0);
        chk("R3", "reset fu_params word 0", fu_params[31:0], 32'd0);

        do_call(8'h11, 3, 0, 1);    // short call, zero latency
        do_call(8'h22, 0, 2, 2);    // no parameters: registers keep values (R3)
        do_call(8'h33, 8, 7, 3);    // full bank, slow unit
        // R5: stray completion while idle
        @(posedge clk); #1 stray_req = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5", "idle after stray fu_done", {31'd0, call_ready}, 32'd1);
        do_call(8'h44, 12, 1, 4);   // count above bank size clamps (R2)
        do_call(8'hA5, 5, 4, 5);    // back-to-back pair: done cleared (R7)
        do_call(8'h5A, 1, 0, 6);
        do_call(8'h00, 2, 9, 7);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule